// File: doc/BRIEF.md
# Port Configuration Lock

This block guards the pin configuration of one 16-pin port. It holds two 32-bit configuration registers with a 4-bit field for each pin. It also holds a lock register with one lock bit per pin and a single key bit. Software chooses which pins to freeze by writing the lock bits. It then arms the key with a fixed access handshake on the lock register. From then on, configuration writes leave the fields of the frozen pins unchanged. Only a reset releases the key.

The handshake uses three writes to the lock register, with the key field set to 1, then 0, then 1. All three writes carry the same pin mask. A read of the lock register then completes the handshake, and that read still returns key = 0. Any other access pattern on the lock register abandons the handshake and leaves the port unlocked. Accesses to other addresses do not affect it.

The register bus has single-cycle write and read strobes, a 2-bit address and 32-bit data in each direction. Read data is combinational, so it is valid in the same cycle as the read strobe. A write takes effect at the clock edge that samples it.

Top module: `pinlock_port`

## Requirements
- R1: After reset the lock bits and the key are 0, and every 4-bit pin field of both configuration registers holds 4'h4 (each register reads 32'h4444_4444).
- R2: Address map: address 0 is the low configuration register, with pin p (0..7) in bits 4p+3:4p. Address 1 is the high configuration register, with pin 8+k in bits 4k+3:4k. Address 2 is the lock register, with the lock bits in 15:0, the key in bit 16, and 0 in bits 31:17. A read of address 3 returns 0. Read data is valid in the cycle the read strobe is high.
- R3: While the key is 0, a write to address 2 loads bits 15:0 into the lock bits. Bit 16 of that write never sets or clears the key directly.
- R4: The key is armed by this exact sequence on address 2: a write with bit 16 = 1, a write with bit 16 = 0, a write with bit 16 = 1, then a read. The three writes must carry equal bits 15:0. The completing read returns bit 16 = 0, and every later read of address 2 returns bit 16 = 1.
- R5: If a write in the sequence carries bits 15:0 that differ from the previous write, the sequence is abandoned. A read that completes that broken sequence leaves the key at 0.
- R6: A read of address 2 before the third write, or a write with bit 16 = 0 where a write with bit 16 = 1 is due, abandons the sequence and leaves the key at 0.
- R7: A write to address 2 with bit 16 = 1 that does not fit the expected step starts a new sequence with its own mask.
- R8: Reads and writes to addresses 0, 1 and 3 between steps do not disturb a sequence in progress.
- R9: Once armed, the key stays 1 until reset. Writes to address 2 change neither the key nor the lock bits.
- R10: While the key is 1, a configuration write updates only the fields of pins whose lock bit is 0. The output frozen shows the lock bits while the key is 1 and shows 0 otherwise.
- R11: While the key is 0, lock bits do not gate configuration writes. Every field takes the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Single-cycle write strobe |
| rd_en | input | 1 | Single-cycle read strobe |
| addr | input | 2 | Register select |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, combinational, 0 when rd_en is low |
| cfg_lo | output | 32 | Configuration fields of pins 0..7 |
| cfg_hi | output | 32 | Configuration fields of pins 8..15 |
| key_active | output | 1 | Lock key armed |
| frozen | output | 16 | Per-pin freeze mask in force |

## Verification
Read data is combinational, so each read result is sampled in the cycle the strobe is high, shortly after the falling edge that drives it. Every register write takes effect at the next rising edge. The bench therefore checks a written value with a read issued in a later cycle. The key changes at the edge that samples the completing read. For that reason the arming read is expected to show 0, and the next read and the key_active port are expected to show 1. Each scenario starts from its own reset because the key cannot be cleared any other way.

// File: rtl/pinlock_pkg.sv
package pinlock_pkg;
    localparam int NPINS        = 16;
    localparam int FLD_W        = 4;
    localparam int DW           = 32;
    localparam int AW           = 2;
    localparam int PINS_PER_REG = DW / FLD_W;
    localparam int NREGS        = NPINS / PINS_PER_REG;
    localparam int KEY_POS      = NPINS;

    typedef enum logic [AW-1:0] {
        A_CFG_LO = 2'd0,
        A_CFG_HI = 2'd1,
        A_LOCK   = 2'd2,
        A_SPARE  = 2'd3
    } reg_addr_e;

    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_ONE,
        SQ_ONE_ZERO,
        SQ_READY
    } seq_state_e;

    typedef struct packed {
        logic             key;
        logic [NPINS-1:0] bits;
    } lock_view_t;

    function automatic logic [DW-1:0] lock_word(input lock_view_t v);
        logic [DW-1:0] w;
        w = '0;
        w[KEY_POS:0] = v;
        return w;
    endfunction
endpackage

// File: rtl/pinlock_seq.sv
module pinlock_seq
    import pinlock_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             lk_wr,
    input  logic             lk_rd,
    input  logic [KEY_POS:0] wfield,
    output lock_view_t       view
);
    seq_state_e       st_q, st_d;
    logic [NPINS-1:0] bits_q;
    logic             key_q, key_d;
    logic             wkey, same;

    assign wkey = wfield[KEY_POS];
    assign same = (wfield[NPINS-1:0] == bits_q);

    always_comb begin
        st_d  = st_q;
        key_d = key_q;
        if (key_q) begin
            st_d = SQ_IDLE;
        end else if (lk_wr) begin
            unique case (st_q)
                SQ_ONE:      st_d = (!wkey && same) ? SQ_ONE_ZERO : (wkey ? SQ_ONE : SQ_IDLE);
                SQ_ONE_ZERO: st_d = (wkey && same)  ? SQ_READY    : (wkey ? SQ_ONE : SQ_IDLE);
                default:     st_d = wkey ? SQ_ONE : SQ_IDLE;
            endcase
        end else if (lk_rd) begin
            st_d = SQ_IDLE;
            if (st_q == SQ_READY) key_d = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= SQ_IDLE;
            key_q  <= 1'b0;
            bits_q <= '0;
        end else begin
            st_q  <= st_d;
            key_q <= key_d;
            if (lk_wr && !key_q) bits_q <= wfield[NPINS-1:0];
        end
    end

    assign view.key  = key_q;
    assign view.bits = bits_q;
endmodule

// File: rtl/pinlock_cfg.sv
module pinlock_cfg
    import pinlock_pkg::*;
#(
    parameter logic [FLD_W-1:0] FLD_RST = 4'h4
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    we,
    input  logic [DW-1:0]           wdata,
    input  logic [PINS_PER_REG-1:0] hold,
    output logic [DW-1:0]           q
);
    for (genvar p = 0; p < PINS_PER_REG; p++) begin : g_fld
        always_ff @(posedge clk) begin
            if (rst)
                q[p*FLD_W +: FLD_W] <= FLD_RST;
            else if (we && !hold[p])
                q[p*FLD_W +: FLD_W] <= wdata[p*FLD_W +: FLD_W];
        end
    end
endmodule

// File: rtl/pinlock_port.sv
module pinlock_port
    import pinlock_pkg::*;
#(
    parameter logic [FLD_W-1:0] FLD_RST = 4'h4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic             rd_en,
    input  logic [AW-1:0]    addr,
    input  logic [DW-1:0]    wdata,
    output logic [DW-1:0]    rdata,
    output logic [DW-1:0]    cfg_lo,
    output logic [DW-1:0]    cfg_hi,
    output logic             key_active,
    output logic [NPINS-1:0] frozen
);
    reg_addr_e        sel;
    lock_view_t       lview;
    logic [DW-1:0]    cfg [NREGS];

    assign sel = reg_addr_e'(addr);

    pinlock_seq u_seq (
        .clk    (clk),
        .rst    (rst),
        .lk_wr  (wr_en && sel == A_LOCK),
        .lk_rd  (rd_en && sel == A_LOCK),
        .wfield (wdata[KEY_POS:0]),
        .view   (lview)
    );

    assign key_active = lview.key;
    assign frozen     = lview.key ? lview.bits : '0;

    for (genvar g = 0; g < NREGS; g++) begin : g_cfg
        pinlock_cfg #(.FLD_RST(FLD_RST)) u_cfg (
            .clk   (clk),
            .rst   (rst),
            .we    (wr_en && addr == AW'(g)),
            .wdata (wdata),
            .hold  (frozen[g*PINS_PER_REG +: PINS_PER_REG]),
            .q     (cfg[g])
        );
    end

    assign cfg_lo = cfg[0];
    assign cfg_hi = cfg[1];

    always_comb begin
        rdata = '0;
        if (rd_en) begin
            unique case (sel)
                A_CFG_LO: rdata = cfg_lo;
                A_CFG_HI: rdata = cfg_hi;
                A_LOCK:   rdata = lock_word(lview);
                default:  rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/pinlock_chk.sv
module pinlock_chk
    import pinlock_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             rd_en,
    input logic [AW-1:0]    addr,
    input logic [DW-1:0]    rdata,
    input lock_view_t       lview,
    input logic [DW-1:0]    cfg_lo,
    input logic [DW-1:0]    cfg_hi,
    input logic [NPINS-1:0] frozen
);
    logic [2*DW-1:0]  prev_cfg;
    logic [NPINS-1:0] prev_frz;
    logic             seen;
    logic [NPINS-1:0] chg;
    logic [2*DW-1:0]  cur_cfg;

    assign cur_cfg = {cfg_hi, cfg_lo};

    always_ff @(posedge clk) begin
        if (rst) seen <= 1'b0;
        else     seen <= 1'b1;
        prev_cfg <= cur_cfg;
        prev_frz <= frozen;
    end

    always_comb begin
        for (int i = 0; i < NPINS; i++)
            chg[i] = prev_cfg[i*FLD_W +: FLD_W] != cur_cfg[i*FLD_W +: FLD_W];
    end

    AST_KEY_STICKY: assert property (@(posedge clk) disable iff (rst)
        lview.key |=> lview.key); // R9

    AST_LOCK_BITS_HELD: assert property (@(posedge clk) disable iff (rst)
        lview.key |=> $stable(lview.bits)); // R9

    AST_ARM_BY_READ: assert property (@(posedge clk) disable iff (rst)
        $rose(lview.key) |-> $past(rd_en && addr == A_LOCK)); // R4

    AST_LOCK_READBACK: assert property (@(posedge clk) disable iff (rst)
        (rd_en && addr == A_LOCK) |-> (rdata[KEY_POS:0] == lview && rdata[DW-1:KEY_POS+1] == '0)); // R2

    AST_FROZEN_FIELDS: assert property (@(posedge clk) disable iff (rst)
        seen |-> ((chg & prev_frz) == '0)); // R10

    AST_FROZEN_IDLE: assert property (@(posedge clk) disable iff (rst)
        !lview.key |-> (frozen == '0)); // R11
endmodule

bind pinlock_port pinlock_chk u_chk (
    .clk    (clk),
    .rst    (rst),
    .rd_en  (rd_en),
    .addr   (addr),
    .rdata  (rdata),
    .lview  (lview),
    .cfg_lo (cfg_lo),
    .cfg_hi (cfg_hi),
    .frozen (frozen)
);

// File: tb/sim_pinlock_port.sv
module sim_pinlock_port;
    logic        clk = 1'b0;
    logic        rst;
    logic        wr_en, rd_en;
    logic [1:0]  addr;
    logic [31:0] wdata, rdata, cfg_lo, cfg_hi;
    logic        key_active;
    logic [15:0] frozen;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    pinlock_port u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .cfg_lo(cfg_lo), .cfg_hi(cfg_hi),
        .key_active(key_active), .frozen(frozen)
    );

    task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; wr_en = 1'b0; rd_en = 1'b0; addr = 2'd0; wdata = '0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        #1 d = rdata;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        do_reset();
        rd(2'd0, d); check("R1", "cfg_lo reset", d, 32'h4444_4444);
        rd(2'd1, d); check("R1", "cfg_hi reset", d, 32'h4444_4444);
        rd(2'd2, d); check("R1", "lock reset", d, 32'h0);
        check("R1", "key_active reset", {31'd0, key_active}, 32'd0);
    endtask

    task automatic t_lock_write();
        logic [31:0] d;
        do_reset();
        wr(2'd2, 32'h0000_A5A5);
        rd(2'd2, d); check("R3", "lock bits written", d, 32'h0000_A5A5);
        wr(2'd2, 32'hFFFF_00FF);
        rd(2'd2, d); check("R3", "key not set by write", d, 32'h0000_00FF);
        rd(2'd3, d); check("R2", "spare address reads zero", d, 32'h0);
        wr(2'd2, 32'h0000_FFFF);
        wr(2'd1, 32'h1234_5678);
        rd(2'd1, d); check("R11", "unarmed lock does not gate", d, 32'h1234_5678);
        check("R11", "frozen while unarmed", {16'd0, frozen}, 32'h0);
    endtask

    task automatic t_mismatch();
        logic [31:0] d;
        do_reset();
        wr(2'd2, 32'h0001_00F0);
        wr(2'd2, 32'h0000_00F0);
        wr(2'd2, 32'h0001_00F1);
        rd(2'd2, d); check("R5", "mask change: read", d, 32'h0000_00F1);
        rd(2'd2, d); check("R5", "mask change: key stays 0", d, 32'h0000_00F1);
    endtask

    task automatic t_abort();
        logic [31:0] d;
        do_reset();
        wr(2'd2, 32'h0001_0005);
        wr(2'd2, 32'h0000_0005);
        rd(2'd2, d); check("R6", "early read", d, 32'h0000_0005);
        wr(2'd2, 32'h0001_0005);
        rd(2'd2, d); check("R6", "after early read", d, 32'h0000_0005);
        wr(2'd2, 32'h0001_0005);
        wr(2'd2, 32'h0000_0005);
        wr(2'd2, 32'h0000_0005);
        wr(2'd2, 32'h0001_0005);
        rd(2'd2, d); check("R6", "extra zero write", d, 32'h0000_0005);
        rd(2'd2, d); check("R6", "key still 0", d, 32'h0000_0005);
    endtask

    task automatic t_restart();
        logic [31:0] d;
        do_reset();
        wr(2'd2, 32'h0001_0003);
        wr(2'd2, 32'h0001_000C);
        wr(2'd2, 32'h0000_000C);
        wr(2'd2, 32'h0001_000C);
        rd(2'd2, d); check("R4", "arming read returns key 0", d, 32'h0000_000C);
        rd(2'd2, d); check("R7", "restart armed with new mask", d, 32'h0001_000C);
        check("R4", "key_active port", {31'd0, key_active}, 32'd1);
    endtask

    task automatic t_other_addr();
        logic [31:0] d;
        do_reset();
        wr(2'd2, 32'h0001_0030);
        wr(2'd0, 32'h1111_1111);
        wr(2'd2, 32'h0000_0030);
        rd(2'd1, d); check("R8", "hi read mid-sequence", d, 32'h4444_4444);
        wr(2'd3, 32'hDEAD_BEEF);
        wr(2'd2, 32'h0001_0030);
        rd(2'd0, d); check("R8", "lo read mid-sequence", d, 32'h1111_1111);
        rd(2'd2, d); check("R8", "arming read", d, 32'h0000_0030);
        rd(2'd2, d); check("R8", "armed despite other accesses", d, 32'h0001_0030);
        wr(2'd0, 32'h9999_9999);
        rd(2'd0, d); check("R10", "pins 4,5 held", d, 32'h9911_9999);
    endtask

    task automatic t_arm_gate();
        logic [31:0] d;
        do_reset();
        wr(2'd2, 32'h0001_8001);
        wr(2'd2, 32'h0000_8001);
        wr(2'd2, 32'h0001_8001);
        rd(2'd2, d); check("R4", "arming read", d, 32'h0000_8001);
        rd(2'd2, d); check("R4", "confirm read", d, 32'h0001_8001);
        check("R10", "frozen port", {16'd0, frozen}, 32'h0000_8001);
        wr(2'd2, 32'h0000_FFFF);
        rd(2'd2, d); check("R9", "lock write ignored", d, 32'h0001_8001);
        wr(2'd2, 32'h0001_0000);
        wr(2'd2, 32'h0000_0000);
        wr(2'd2, 32'h0001_0000);
        rd(2'd2, d);
        rd(2'd2, d); check("R9", "key and bits after new sequence", d, 32'h0001_8001);
        wr(2'd0, 32'hAAAA_AAAA);
        rd(2'd0, d); check("R10", "pin 0 held", d, 32'hAAAA_AAA4);
        check("R2", "cfg_lo port", cfg_lo, 32'hAAAA_AAA4);
        wr(2'd1, 32'hBBBB_BBBB);
        rd(2'd1, d); check("R10", "pin 15 held", d, 32'h4BBB_BBBB);
        check("R2", "cfg_hi port", cfg_hi, 32'h4BBB_BBBB);
        check("R9", "key_active stays", {31'd0, key_active}, 32'd1);
    endtask

    initial begin
        rst = 1'b1; wr_en = 1'b0; rd_en = 1'b0; addr = 2'd0; wdata = '0;
        t_reset();
        t_lock_write();
        t_mismatch();
        t_abort();
        t_restart();
        t_other_addr();
        t_arm_gate();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule